// File: doc/BRIEF.md
# Timer-Paced SPI Master Shifter

This block is an 8-bit SPI master that sends and receives one byte at a time in SPI mode 0. It has no fixed divider for the serial clock. A free-running period timer inside the block paces the bit rate instead. The timer has a prescaler, an up-counter and a period compare value. Each time the counter reaches the compare value it wraps to zero and produces one match pulse. During a transfer, the serial clock toggles once on every match pulse. One serial clock period therefore spans two match intervals.

A host drives a small register port. Through it the host starts and stops the timer, chooses the prescale, sets the period, presets or reads the counter, loads the byte to send, reads back the byte received, and reads or clears the sticky status bits. Loading the data register does not touch the timer. If the timer is already running at the load, the first bit time is shortened by however much of the current match interval has already passed. Software gets exact bit times by following this order: stop the timer, zero the counter, load the byte, start the timer.

Top module: `tmr_spi_master`

## Requirements
- R1: After reset, SCK and MOSI are low, and every host register reads zero. The register addresses are: 0 control (bit 0 runs the timer, bits 2:1 select the prescale), 1 period, 2 counter, 3 data, 4 status (bit 0 done, bit 1 collision).
- R2: While the timer runs, a match occurs every (period+1)*D clock cycles. D is 1, 4, 16 or 16 for prescale select values 0, 1, 2 and 3. The counter returns to zero at each match.
- R3: While the timer is stopped, the counter keeps its value. A write to address 2 sets the counter, and a read of address 2 returns it.
- R4: During a transfer, SCK changes only on a match, once per match. SCK sits low for the first match interval of each bit and high for the second, and it is low when no transfer is in progress.
- R5: Bits go out MSb first. MOSI changes only when a byte is loaded and on falling SCK edges. MISO is sampled on each rising SCK edge.
- R6: A data write leaves the timer untouched. With the order stop, zero, load, start, every bit lasts exactly two match intervals, measured from the start of the timer. With the timer running at the load, only the first bit is shorter.
- R7: The done bit sets on the eighth falling SCK edge and stays set until the host writes 1 to status bit 0.
- R8: A read of address 3 returns the byte received during the last completed transfer.
- R9: A data write during a transfer is ignored: the byte being sent does not change. The write sets the collision bit, which stays set until the host writes 1 to status bit 1.
- R10: After a transfer completes, MOSI returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A register write takes effect at the next edge, and its value can be read combinationally in the following cycle. A started timer with a zeroed counter raises SCK N edges later and drops it 2N edges later, where N is (period+1)*D. The done bit and the received byte update at the same edge as the eighth falling SCK edge. The bench counts edges with its own cycle counter and samples every output at the falling clock edge. A behavioural model, stepped at each rising edge, predicts SCK and MOSI for every cycle. Bit widths are checked against these exact edge counts.

// File: rtl/tmr_spi_pkg.sv
package tmr_spi_pkg;
  typedef struct packed {
    logic loadTx;
    logic sampleRx;
    logic shiftTx;
    logic commitRx;
  } shiftStrobe_t;

  localparam int REG_CTRL   = 0;
  localparam int REG_PERIOD = 1;
  localparam int REG_COUNT  = 2;
  localparam int REG_DATA   = 3;
  localparam int REG_STATUS = 4;
endpackage

// File: rtl/tmr_spi_datapath.sv
module tmr_spi_datapath
  import tmr_spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PS_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              perWr,
  input  logic              cntWr,
  input  logic [DATA_W-1:0] wrData,
  input  shiftStrobe_t      strobe,
  input  logic              miso,
  output logic              match,
  output logic              mosi,
  output logic              tmrEn,
  output logic [1:0]        psSel,
  output logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] rxBuf
);
  logic [PS_W-1:0]   psQ;
  logic [PS_W-1:0]   psLast;
  logic [DATA_W-1:0] txQ;
  logic [DATA_W-1:0] rxShQ;
  logic              tick;

  // divide by 1, 4, 16, 16
  always_comb begin
    case (psSel)
      2'd0:    psLast = '0;
      2'd1:    psLast = PS_W'(3);
      default: psLast = PS_W'(15);
    endcase
  end

  assign tick  = tmrEn && (psQ == psLast);
  assign match = tick && (count == period);
  assign mosi  = txQ[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrEn  <= 1'b0;
      psSel  <= '0;
      period <= '0;
      count  <= '0;
      psQ    <= '0;
    end else begin
      if (ctrlWr) begin
        tmrEn <= wrData[0];
        psSel <= wrData[2:1];
      end
      if (perWr) period <= wrData;
      if (cntWr) begin
        count <= wrData;
        psQ   <= '0;
      end else if (tmrEn) begin
        if (tick) begin
          psQ   <= '0;
          count <= match ? '0 : count + 1'b1;
        end else begin
          psQ <= psQ + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQ   <= '0;
      rxShQ <= '0;
      rxBuf <= '0;
    end else begin
      if (strobe.loadTx)       txQ <= wrData;
      else if (strobe.shiftTx) txQ <= {txQ[DATA_W-2:0], 1'b0};
      if (strobe.sampleRx) rxShQ <= {rxShQ[DATA_W-2:0], miso};
      if (strobe.commitRx) rxBuf <= rxShQ;
    end
  end

  logic txMove;
  assign txMove = strobe.loadTx || strobe.shiftTx;

  a_r3_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    $past(!tmrEn && !cntWr) |-> (count == $past(count)));
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(match && !cntWr) |-> (count == '0));
  a_r5_mosi_moves: assert property (@(posedge clk) disable iff (!rstN)
    (mosi != $past(mosi)) |-> $past(txMove));
endmodule

// File: rtl/tmr_spi_ctrl.sv
module tmr_spi_ctrl
  import tmr_spi_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dataWr,
  input  logic         clrDone,
  input  logic         clrColl,
  input  logic         match,
  output shiftStrobe_t strobe,
  output logic         sck,
  output logic         done,
  output logic         coll
);
  localparam int CNT_W = $clog2(BITS);

  logic             busyQ;
  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;

  assign lastBit = (bitCnt == CNT_W'(BITS - 1));

  always_comb begin
    strobe = '0;
    if (!busyQ && dataWr) strobe.loadTx = 1'b1;
    if (busyQ && match) begin
      if (!sck) begin
        strobe.sampleRx = 1'b1;
      end else begin
        strobe.shiftTx  = 1'b1;
        strobe.commitRx = lastBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      bitCnt <= '0;
      sck    <= 1'b0;
      done   <= 1'b0;
      coll   <= 1'b0;
    end else begin
      if (strobe.loadTx) begin
        busyQ  <= 1'b1;
        bitCnt <= '0;
      end
      if (strobe.sampleRx) sck <= 1'b1;
      if (strobe.shiftTx) begin
        sck <= 1'b0;
        if (lastBit) busyQ <= 1'b0;
        else         bitCnt <= bitCnt + 1'b1;
      end
      if (strobe.commitRx) done <= 1'b1;
      else if (clrDone)    done <= 1'b0;
      if (busyQ && dataWr) coll <= 1'b1;
      else if (clrColl)    coll <= 1'b0;
    end
  end

  logic finishing;
  assign finishing = strobe.commitRx;

  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !sck);
  a_r4_sck_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (sck != $past(sck)) |-> $past(match));
  a_r7_done_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(finishing));
  a_r9_coll_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coll) |-> $past(busyQ && dataWr));
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && dataWr && !match) |=> (bitCnt == $past(bitCnt)));
endmodule

// File: rtl/tmr_spi_master.sv
module tmr_spi_master
  import tmr_spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  shiftStrobe_t      strobe;
  logic              match, tmrEn, done, coll;
  logic [1:0]        psSel;
  logic [DATA_W-1:0] period, count, rxBuf;
  logic              ctrlWr, perWr, cntWr, dataWr, statWr;

  assign ctrlWr = wrEn && (addr == ADDR_W'(REG_CTRL));
  assign perWr  = wrEn && (addr == ADDR_W'(REG_PERIOD));
  assign cntWr  = wrEn && (addr == ADDR_W'(REG_COUNT));
  assign dataWr = wrEn && (addr == ADDR_W'(REG_DATA));
  assign statWr = wrEn && (addr == ADDR_W'(REG_STATUS));

  tmr_spi_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .perWr(perWr), .cntWr(cntWr),
    .wrData(wrData), .strobe(strobe), .miso(miso), .match(match),
    .mosi(mosi), .tmrEn(tmrEn), .psSel(psSel), .period(period),
    .count(count), .rxBuf(rxBuf)
  );

  tmr_spi_ctrl #(.BITS(DATA_W)) uCtl (
    .clk(clk), .rstN(rstN), .dataWr(dataWr),
    .clrDone(statWr && wrData[0]), .clrColl(statWr && wrData[1]),
    .match(match), .strobe(strobe), .sck(sck), .done(done), .coll(coll)
  );

  always_comb begin
    case (int'(addr))
      REG_CTRL:   rdData = {{(DATA_W-3){1'b0}}, psSel, tmrEn};
      REG_PERIOD: rdData = period;
      REG_COUNT:  rdData = count;
      REG_DATA:   rdData = rxBuf;
      REG_STATUS: rdData = {{(DATA_W-2){1'b0}}, coll, done};
      default:    rdData = '0;
    endcase
  end
endmodule

// File: tb/tb_tmr_spi_master.sv
module tb_tmr_spi_master;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       sck, mosi, miso;

  always #10 clk = ~clk;

  tmr_spi_master dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int shown = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference model
  int mEn = 0, mSel = 0, mPer = 0, mCnt = 0, mPs = 0;
  int mBusy = 0, mBit = 0, mSck = 0, mTx = 0;
  always @(posedge clk) begin
    int dv;
    bit tk, mt;
    if (!rstN) begin
      mEn = 0; mSel = 0; mPer = 0; mCnt = 0; mPs = 0;
      mBusy = 0; mBit = 0; mSck = 0; mTx = 0;
    end else begin
      dv = (mSel == 0) ? 1 : (mSel == 1) ? 4 : 16;
      tk = (mEn != 0) && (mPs == dv - 1);
      mt = tk && (mCnt == mPer);
      if (mBusy != 0 && mt) begin
        if (mSck == 0) mSck = 1;
        else begin
          mSck = 0;
          mTx = (mTx * 2) % 256;
          if (mBit == 7) mBusy = 0; else mBit++;
        end
      end else if (mBusy == 0 && wrEn && addr == 3) begin
        mBusy = 1; mBit = 0; mTx = wrData;
      end
      if (wrEn && addr == 2) begin mCnt = wrData; mPs = 0; end
      else if (mEn != 0) begin
        if (tk) begin mPs = 0; mCnt = mt ? 0 : (mCnt + 1) % 256; end
        else mPs++;
      end
      if (wrEn && addr == 0) begin mEn = wrData[0]; mSel = wrData[2:1]; end
      if (wrEn && addr == 1) mPer = wrData;
    end
  end

  // per-cycle comparison, edge monitor and MISO responder
  logic [7:0] slvReg = '0;
  logic [7:0] capByte = '0;
  logic       prevSck = 1'b0;
  int riseQ[$];
  int fallQ[$];
  assign miso = slvReg[7];

  always @(negedge clk) begin
    if (rstN) begin
      checks += 2;
      if (sck !== mSck[0] || mosi !== mTx[7]) begin
        errors++;
        if (shown < 10) begin
          shown++;
          $display("FAIL R4/R5 model: actual sck=%0d mosi=%0d expected sck=%0d mosi=%0d",
                   sck, mosi, mSck[0], mTx[7]);
        end
      end
      if (sck && !prevSck) begin
        riseQ.push_back(cyc);
        capByte = {capByte[6:0], mosi};
      end
      if (!sck && prevSck) begin
        fallQ.push_back(cyc);
        slvReg = {slvReg[6:0], 1'b0};
      end
      prevSck = sck;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 20000 && fallQ.size() < 8; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clearMon();
    riseQ.delete();
    fallQ.delete();
    capByte = '0;
  endtask

  task automatic presetRun(input int sel, input int per, input logic [7:0] tx,
                           input logic [7:0] rx);
    int n, dv, enCyc;
    dv = (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
    n = (per + 1) * dv;
    wr(0, 8'(sel << 1));
    wr(1, 8'(per));
    wr(2, 8'h00);
    clearMon();
    slvReg = rx;
    wr(3, tx);
    wr(0, 8'((sel << 1) | 1));
    enCyc = cyc;
    waitEnd();
    chk("R6 preset bit count", fallQ.size(), 8);
    if (fallQ.size() == 8 && riseQ.size() == 8) begin
      chk("R6 preset MSb width", fallQ[0] - enCyc, 2 * n);
      for (int i = 1; i < 8; i++) chk("R6 preset bit width", fallQ[i] - fallQ[i-1], 2 * n);
      for (int i = 0; i < 8; i++) chk("R4 SCK high time", fallQ[i] - riseQ[i], n);
      chk("R2 match interval", riseQ[0] - enCyc, n);
    end
    chk("R5 MSb-first byte", capByte, tx);
    rdChk(4, 8'h01, "R7 done set");
    repeat (5) @(negedge clk);
    rdChk(4, 8'h01, "R7 done sticky");
    rdChk(3, rx, "R8 received byte");
    chk("R10 MOSI idle low", mosi, 1'b0);
    wr(4, 8'h01);
    rdChk(4, 8'h00, "R7 done cleared");
    wr(0, 8'(sel << 1));
  endtask

  task automatic mainSeq();
    int n, enCyc, wStart;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 sck reset", sck, 1'b0);
    chk("R1 mosi reset", mosi, 1'b0);
    for (int a = 0; a < 5; a++) rdChk(3'(a), 8'h00, "R1 register reset");

    // counter hold and preset while stopped
    wr(2, 8'h07);
    repeat (10) @(negedge clk);
    rdChk(2, 8'h07, "R3 counter holds");

    presetRun(1, 2, 8'h3C, 8'hA5);
    presetRun(0, 1, 8'h81, 8'h7E);
    presetRun(2, 0, 8'hF0, 8'h0F);
    presetRun(3, 0, 8'h55, 8'h96);

    // running timer at load, plus a colliding write
    n = 20;
    wr(0, 8'h02);
    wr(1, 8'd4);
    wr(2, 8'h00);
    wr(0, 8'h03);
    enCyc = cyc;
    repeat (7) @(negedge clk);
    clearMon();
    slvReg = 8'h5A;
    wr(3, 8'hC3);
    wStart = cyc;
    while (riseQ.size() == 0) @(negedge clk);
    wr(3, 8'hFF);
    waitEnd();
    chk("R6 phase bit count", fallQ.size(), 8);
    if (fallQ.size() == 8) begin
      chk("R6 first bit shortened", fallQ[0] - wStart, 2 * n - (wStart - enCyc));
      chk("R6 first bit below nominal", (fallQ[0] - wStart) < 2 * n, 1);
      for (int i = 1; i < 8; i++) chk("R6 later bits nominal", fallQ[i] - fallQ[i-1], 2 * n);
    end
    chk("R9 byte unchanged by collision", capByte, 8'hC3);
    rdChk(3, 8'h5A, "R8 received byte");
    rdChk(4, 8'h03, "R9 collision and done set");
    wr(4, 8'h02);
    rdChk(4, 8'h01, "R9 collision cleared alone");
    wr(4, 8'h01);
    rdChk(4, 8'h00, "R7 done cleared");
    wr(0, 8'h02);
    rdChk(0, 8'h02, "R3 timer stopped");
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule